// File: doc/BRIEF.md
# Variable Rate Bit Packer

This block collects a serial bit stream that arrives at a varying rate, between zero and two bits per clock, and packs it into 8-bit words. It sits behind a receiver front end whose local clock runs slightly faster or slower than the incoming stream. Such a front end sometimes produces no bit in a cycle and sometimes produces two. Each input cycle carries a 2-bit data bus and a 2-bit valid bus. Lane 0 always holds the earlier bit, and lane 1 is valid only when lane 0 is valid too.

The block keeps a shift register one bit wider than a word, plus a fill counter. New bits enter at the top of the register and older bits move toward bit 0. A fill of seven plus two incoming bits reaches nine without losing anything. When the fill reaches a full word, an output multiplexer picks the oldest eight bits. One of two windows is used, depending on whether the fill is exactly eight or nine. The word is registered together with a one-cycle strobe, and a ninth bit is carried into the next word.

Top module: `bit_packer`

## Requirements
- R1: Synchronous reset (`rst_i` high at a rising edge) clears the fill count to zero, drives `word_o` to 0 and keeps `word_stb_o` low. After reset, exactly eight bits are needed before the first strobe.
- R2: A cycle with `vld_i` = 2'b00 does not change the fill or the stored bits, and raises no strobe.
- R3: With `vld_i` = 2'b01, only `bit_i[0]` is accepted and the fill rises by one.
- R4: With `vld_i` = 2'b11, both bits are accepted in one cycle and the fill rises by two. `bit_i[0]` counts as older than `bit_i[1]`.
- R5: When the fill reaches exactly eight, `word_o` is loaded with the eight collected bits and the fill returns to zero.
- R6: When the fill would reach nine, `word_o` is loaded with the oldest eight bits. The newest bit stays as the first bit of the next word, with a fill of one.
- R7: `word_stb_o` is high for exactly one cycle per completed word. It rises right after the edge that accepted the word's last bit, with `word_o` valid in that same cycle.
- R8: `vld_i` = 2'b10 is treated as no data. It changes neither the fill nor the stored bits and raises no strobe, whatever `bit_i` holds.
- R9: `word_o` holds its value in every cycle where `word_stb_o` is low.
- R10: A reset in the middle of a word discards the partially collected bits.
- R11: Word bit order: `word_o[0]` is the earliest received bit of the word and `word_o[7]` the latest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 2 | Incoming bits; lane 0 is the earlier one |
| vld_i | input | 2 | Lane valid flags: 00 none, 01 lane 0, 11 both, 10 ignored |
| word_o | output | 8 | Packed word, earliest bit in bit 0 |
| word_stb_o | output | 1 | One-cycle strobe marking a new word on `word_o` |

## Verification
An input pair is accepted at the rising edge where it is presented. Any word it completes appears on `word_o`, with the strobe, immediately after that same edge, a latency of one register. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. In that window it compares the strobe and word against a queue of every accepted bit in arrival order. In cycles with no strobe it checks that the strobe stays low and that the word is unchanged.

// File: rtl/bpk_pkg.sv
package bpk_pkg;

    typedef enum logic [1:0] {
        LANES_NONE = 2'b00,
        LANES_ONE  = 2'b01,
        LANES_BAD  = 2'b10,
        LANES_TWO  = 2'b11
    } lanes_e;

    // number of bits a lane pattern contributes; the unordered pattern counts as none
    function automatic logic [1:0] lanes_to_count(input logic [1:0] vld);
        logic [1:0] n;
        case (lanes_e'(vld))
            LANES_ONE: n = 2'd1;
            LANES_TWO: n = 2'd2;
            default:   n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bpk_lane_decode.sv
module bpk_lane_decode
    import bpk_pkg::*;
(
    input  logic [1:0] vld_i,
    output logic [1:0] take_o
);
    always_comb begin
        take_o = lanes_to_count(vld_i);
    end
endmodule

// File: rtl/bpk_fill_shifter.sv
module bpk_fill_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        take_i,
    input  logic [1:0]        bit_i,
    output logic [WORD_W:0]   sr_next_o,
    output logic [$clog2(WORD_W+2)-1:0] sum_o,
    output logic              done_o,
    output logic [$clog2(WORD_W+2)-1:0] fill_o
);
    localparam int SR_W  = WORD_W + 1;
    localparam int CNT_W = $clog2(WORD_W + 2);

    typedef struct packed {
        logic [SR_W-1:0]  sr;
        logic [CNT_W-1:0] cnt;
    } fill_state_t;

    fill_state_t st_d, st_q;
    logic [SR_W-1:0]  sr_shift;
    logic [CNT_W-1:0] sum;
    logic             done;

    always_comb begin
        sr_shift = st_q.sr;
        case (take_i)
            2'd1:    sr_shift = {bit_i[0], st_q.sr[SR_W-1:1]};
            2'd2:    sr_shift = {bit_i[1], bit_i[0], st_q.sr[SR_W-1:2]};
            default: sr_shift = st_q.sr;
        endcase
        sum  = st_q.cnt + CNT_W'(take_i);
        done = (sum >= CNT_W'(WORD_W));

        st_d.sr  = sr_shift;
        st_d.cnt = done ? (sum - CNT_W'(WORD_W)) : sum;
        if (rst_i) begin
            st_d.sr  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sr_next_o = sr_shift;
    assign sum_o     = sum;
    assign done_o    = done & ~rst_i;
    assign fill_o    = st_q.cnt;
endmodule

// File: rtl/bpk_word_select.sv
module bpk_word_select #(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W:0]             sr_i,
    input  logic [$clog2(WORD_W+2)-1:0] sum_i,
    output logic [WORD_W-1:0]           word_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

    logic over;
    assign over = (sum_i == OVER);

    for (genvar g = 0; g < WORD_W; g++) begin : g_pick
        // a full-plus-one fill keeps the oldest bits in the low window
        assign word_o[g] = over ? sr_i[g] : sr_i[g+1];
    end
endmodule

// File: rtl/bit_packer.sv
module bit_packer #(
    parameter int WORD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        bit_i,
    input  logic [1:0]        vld_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_stb_o
);
    localparam int SR_W  = WORD_W + 1;
    localparam int CNT_W = $clog2(WORD_W + 2);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              stb;
    } out_state_t;

    logic [1:0]        take;
    logic [SR_W-1:0]   sr_next;
    logic [CNT_W-1:0]  sum;
    logic              done;
    logic [CNT_W-1:0]  fill_cnt;
    logic [WORD_W-1:0] picked;
    out_state_t        out_d, out_q;

    bpk_lane_decode u_decode (
        .vld_i  (vld_i),
        .take_o (take)
    );

    bpk_fill_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .take_i    (take),
        .bit_i     (bit_i),
        .sr_next_o (sr_next),
        .sum_o     (sum),
        .done_o    (done),
        .fill_o    (fill_cnt)
    );

    bpk_word_select #(.WORD_W(WORD_W)) u_select (
        .sr_i   (sr_next),
        .sum_i  (sum),
        .word_o (picked)
    );

    always_comb begin
        out_d.stb  = done;
        out_d.word = done ? picked : out_q.word;
        if (rst_i) begin
            out_d.stb  = 1'b0;
            out_d.word = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        out_q <= out_d;
    end

    assign word_o     = out_q.word;
    assign word_stb_o = out_q.stb;
endmodule

// File: rtl/bit_packer_chk.sv
module bit_packer_chk #(
    parameter int WORD_W = 8
) (
    input logic                        clk_i,
    input logic                        rst_i,
    input logic [1:0]                  vld_i,
    input logic [WORD_W-1:0]           word_o,
    input logic                        word_stb_o,
    input logic [$clog2(WORD_W+2)-1:0] fill_cnt
);
    localparam int CNT_W = $clog2(WORD_W + 2);

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        rst_i |=> (!word_stb_o && fill_cnt == '0 && word_o == '0));

    assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i == 2'b00) |=> (!word_stb_o && $stable(fill_cnt)));

    assert_single_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i == 2'b01 && fill_cnt < CNT_W'(WORD_W - 1))
        |=> (!word_stb_o && fill_cnt == CNT_W'($past(fill_cnt) + 1'b1)));

    assert_exact_word_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i == 2'b11 && fill_cnt == CNT_W'(WORD_W - 2))
        |=> (word_stb_o && fill_cnt == '0));

    assert_carry_one_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i == 2'b11 && fill_cnt == CNT_W'(WORD_W - 1))
        |=> (word_stb_o && fill_cnt == CNT_W'(1)));

    assert_stb_single_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        word_stb_o |=> !word_stb_o);

    assert_bad_lanes_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i == 2'b10) |=> (!word_stb_o && $stable(fill_cnt)));

    assert_word_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !word_stb_o |-> $stable(word_o));
endmodule

bind bit_packer bit_packer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .vld_i      (vld_i),
    .word_o     (word_o),
    .word_stb_o (word_stb_o),
    .fill_cnt   (fill_cnt)
);

// File: tb/bit_packer_tb_top.sv
`timescale 1ns/1ps
module bit_packer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bits = 2'b00;
    logic [1:0] vld  = 2'b00;
    logic [7:0] word;
    logic       stb;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;
    logic q[$];
    logic [7:0] last_word = 8'h00;

    always #5 clk = ~clk;

    bit_packer dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .bit_i      (bits),
        .vld_i      (vld),
        .word_o     (word),
        .word_stb_o (stb)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle, then compare against the bit queue right after the edge
    task automatic push(input logic [1:0] v, input logic [1:0] b, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        vld  = v;
        bits = b;
        @(posedge clk);
        #1;
        if (v == 2'b01) q.push_back(b[0]);
        if (v == 2'b11) begin
            q.push_back(b[0]);
            q.push_back(b[1]);
        end
        if (q.size() >= 8) begin
            for (int i = 0; i < 8; i++) exp[i] = q[i];
            for (int i = 0; i < 8; i++) void'(q.pop_front());
            check(stb === 1'b1, {tag, " R7 strobe"}, 32'(stb), 32'd1);
            check(word === exp, {tag, " R11 word"}, 32'(word), 32'(exp));
            last_word = exp;
        end else begin
            check(stb === 1'b0, {tag, " R7 no strobe"}, 32'(stb), 32'd0);
            check(word === last_word, {tag, " R9 hold"}, 32'(word), 32'(last_word));
        end
        vld  = 2'b00;
        bits = 2'b00;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        vld = 2'b00;
        repeat (2) @(posedge clk);
        #1;
        check(stb === 1'b0, {tag, " R1 strobe"}, 32'(stb), 32'd0);
        check(word === 8'h00, {tag, " R1 word"}, 32'(word), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        last_word = 8'h00;
    endtask

    task automatic send_singles(input logic [7:0] pat, input int n, input string tag);
        for (int i = 0; i < n; i++) push(2'b01, {1'b0, pat[i]}, tag);
    endtask

    task automatic t_reset_fill();
        do_reset("R1");
        send_singles(8'hA5, 8, "R1");
        check(last_word === 8'hA5, "R1 first word", 32'(last_word), 32'hA5);
    endtask

    task automatic t_singles();
        send_singles(8'h3B, 8, "R3");
        check(last_word === 8'h3B, "R3 R5 word", 32'(last_word), 32'h3B);
    endtask

    task automatic t_pairs();
        for (int i = 0; i < 4; i++) push(2'b11, 2'b01, "R4");
        check(last_word === 8'h55, "R4 pair order", 32'(last_word), 32'h55);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 8; i++) begin
            push(2'b01, {1'b0, 1'(i % 3 == 0)}, "R2");
            push(2'b00, 2'b11, "R2");
        end
        check(last_word === 8'h49, "R2 word", 32'(last_word), 32'h49);
    endtask

    task automatic t_ignored();
        for (int i = 0; i < 8; i++) begin
            push(2'b10, 2'b11, "R8");
            push(2'b01, {1'b0, 1'(i[0])}, "R8");
        end
        check(last_word === 8'hAA, "R8 word", 32'(last_word), 32'hAA);
    endtask

    task automatic t_jump();
        send_singles(8'h00, 7, "R6");
        push(2'b11, 2'b11, "R6");
        check(last_word === 8'h80, "R6 split word", 32'(last_word), 32'h80);
        send_singles(8'hFF, 7, "R6");
        check(last_word === 8'hFF, "R6 carried bit", 32'(last_word), 32'hFF);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 6; i++) push(2'b00, 2'b00, "R9");
    endtask

    task automatic t_midreset();
        send_singles(8'h1F, 5, "R10");
        do_reset("R10");
        send_singles(8'hC3, 8, "R10");
        check(last_word === 8'hC3, "R10 fresh word", 32'(last_word), 32'hC3);
    endtask

    task automatic t_mixed();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            push(lfsr[1:0], lfsr[3:2], "R5 R6 mixed");
        end
    endtask

    initial begin
        t_reset_fill();
        t_singles();
        t_pairs();
        t_idle();
        t_ignored();
        t_jump();
        t_hold();
        t_midreset();
        t_mixed();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule